// File: doc/BRIEF.md
# Terminal Flag I/O and Interrupt Entry Unit

This unit sits beside the sequencer of a small accumulator machine and owns the terminal character path together with the interrupt entry logic. A keyboard-side strobe delivers an 8-bit code into an input holding register and raises an input-ready flag. The processor later moves that code into the low byte of its accumulator, which lowers the flag. In the other direction, the processor places the accumulator's low byte into an output holding register. This lowers an output-ready flag, and a done pulse from the printer raises the flag again.

A software-controlled enable bit decides whether the ready flags may raise a pending request. The pending bit is only captured on an edge that falls outside the first three fetch steps. At an instruction boundary with a request pending, the unit takes over from the fetch for three steps. It saves the program counter into word 0, sends the counter to word 1, and drops both the enable and the pending bit. Memory writes and counter loads go out as command strobes to the surrounding processor model.

Top module: `io_intr_unit`

## Requirements
- R1: After reset, in_ready=0, out_ready=1, overrun=0, int_enable=0, int_pending=0 and intr_busy=0.
- R2: A char_valid pulse while in_ready=0 stores char_data into in_data and sets in_ready on the same edge.
- R3: A char_valid pulse while in_ready=1 leaves in_data unchanged and sets the sticky overrun bit.
- R4: cmd_take_in clears in_ready and overrun on the next edge.
- R5: cmd_load_out while out_ready=1 stores acc_lo into out_data and clears out_ready. A print_done pulse sets out_ready.
- R6: cmd_load_out while out_ready=0 is ignored, and out_data keeps its value.
- R7: cmd_int_on sets int_enable. cmd_int_off clears it, and cmd_int_off wins when both are asserted together.
- R8: int_pending is set on an edge only when int_enable=1, (in_ready or out_ready)=1, and fetch_busy=0.
- R9: With int_pending=1, cycle_start marks entry step 0 (intr_busy=1) and captures pc_in. In step 1, mem_we=1, mem_addr=0, mem_wdata=pc_in zero-extended, pc_load=1 and pc_value=0. In step 2, pc_load=1 and pc_value=1. After step 2, int_enable=0, int_pending=0 and intr_busy=0.
- R10: cycle_start with int_pending=0 produces no memory write, no counter load and no intr_busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_valid | input | 1 | Device strobe: a character has arrived |
| char_data | input | 8 | Arriving character code |
| print_done | input | 1 | Device strobe: printing has finished |
| acc_lo | input | 8 | Low byte of the accumulator |
| cmd_take_in | input | 1 | Move the input character to the accumulator |
| cmd_load_out | input | 1 | Load the output register from acc_lo |
| cmd_int_on | input | 1 | Set the interrupt enable |
| cmd_int_off | input | 1 | Clear the interrupt enable |
| fetch_busy | input | 1 | High during fetch steps 0 to 2 |
| cycle_start | input | 1 | Instruction boundary: step 0 would begin |
| pc_in | input | 12 | Current program counter |
| in_data | output | 8 | Input holding register |
| in_ready | output | 1 | Input-ready flag |
| overrun | output | 1 | A character was dropped |
| out_data | output | 8 | Output holding register |
| out_ready | output | 1 | Output-ready flag |
| int_enable | output | 1 | Interrupt enable |
| int_pending | output | 1 | Pending interrupt |
| intr_busy | output | 1 | Interrupt entry in progress |
| mem_we | output | 1 | Write strobe for the save word |
| mem_addr | output | 12 | Write address |
| mem_wdata | output | 16 | Write data |
| pc_load | output | 1 | Load the program counter |
| pc_value | output | 12 | Value for the program counter |

## Verification
The hardest state to reach is entry into the interrupt sequence. Setting the pending bit needs three things at once: the enable, a raised ready flag, and an edge outside the fetch window. Entry itself also needs an instruction boundary. Because the output flag is high out of reset, the pending bit would otherwise be set as soon as the enable is. The stimulus therefore holds fetch_busy high while it enables interrupts and first tries a boundary with nothing pending. It then drops fetch_busy for a single edge and raises cycle_start with a known counter value, following the save and vector strobes step by step.

// File: rtl/io_intr_pkg.sv
package io_intr_pkg;
  typedef enum logic [1:0] {
    ENT_IDLE   = 2'd0,
    ENT_SAVE   = 2'd1,
    ENT_VECTOR = 2'd2
  } entry_state_e;
endpackage

// File: rtl/io_in_port.sv
module io_in_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arrive,
  input  logic [DATA_W-1:0] arrive_data,
  input  logic              take,
  output logic [DATA_W-1:0] data_q,
  output logic              ready_q,
  output logic              lost_q
);
  logic [DATA_W-1:0] data_d;
  logic              ready_d;
  logic              lost_d;
  logic              data_en;

  always_comb begin
    data_en = arrive && !ready_q;
    data_d  = arrive_data;
    ready_d = ready_q;
    lost_d  = lost_q;
    if (arrive && ready_q) lost_d = 1'b1;
    if (data_en)           ready_d = 1'b1;
    if (take) begin
      ready_d = 1'b0;
      lost_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      lost_q  <= 1'b0;
    end else begin
      ready_q <= ready_d;
      lost_q  <= lost_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end
endmodule

// File: rtl/io_out_port.sv
module io_out_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              done,
  output logic [DATA_W-1:0] data_q,
  output logic              ready_q
);
  logic load_en;
  logic ready_d;

  always_comb begin
    load_en = load && ready_q;
    ready_d = ready_q;
    if (done)    ready_d = 1'b1;
    if (load_en) ready_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b1;
    else        ready_q <= ready_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (load_en) data_q <= load_data;
  end
endmodule

// File: rtl/io_intr_ctrl.sv
module io_intr_ctrl
  import io_intr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ion,
  input  logic              iof,
  input  logic              flag_any,
  input  logic              fetch_busy,
  input  logic              cycle_start,
  input  logic [ADDR_W-1:0] pc_in,
  output logic              ien_q,
  output logic              pend_q,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_value
);
  localparam logic [ADDR_W-1:0] SAVE_ADDR = '0;
  localparam logic [ADDR_W-1:0] VEC_ADDR  = SAVE_ADDR + 1'b1;
  localparam int                PAD_W     = WORD_W - ADDR_W;

  entry_state_e      st_q, st_d;
  logic [ADDR_W-1:0] tr_q;
  logic              tr_en;
  logic              go;
  logic              ien_d, pend_d;

  always_comb begin
    go     = (st_q == ENT_IDLE) && cycle_start && pend_q;
    tr_en  = go;
    st_d   = st_q;
    ien_d  = ien_q;
    pend_d = pend_q;
    unique case (st_q)
      ENT_IDLE:   if (go) st_d = ENT_SAVE;
      ENT_SAVE:   st_d = ENT_VECTOR;
      ENT_VECTOR: st_d = ENT_IDLE;
      default:    st_d = ENT_IDLE;
    endcase
    if (ion) ien_d = 1'b1;
    if (iof) ien_d = 1'b0;
    if (ien_q && flag_any && !fetch_busy) pend_d = 1'b1;
    if (st_q == ENT_VECTOR) begin
      ien_d  = 1'b0;
      pend_d = 1'b0;
    end
  end

  always_comb begin
    busy      = go || (st_q != ENT_IDLE);
    mem_we    = (st_q == ENT_SAVE);
    mem_addr  = SAVE_ADDR;
    mem_wdata = {{PAD_W{1'b0}}, tr_q};
    pc_load   = (st_q == ENT_SAVE) || (st_q == ENT_VECTOR);
    pc_value  = (st_q == ENT_VECTOR) ? VEC_ADDR : SAVE_ADDR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENT_IDLE;
      ien_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ien_q  <= ien_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tr_q <= '0;
    else if (tr_en) tr_q <= pc_in;
  end
endmodule

// File: rtl/io_intr_unit.sv
module io_intr_unit #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_valid,
  input  logic [DATA_W-1:0] char_data,
  input  logic              print_done,
  input  logic [DATA_W-1:0] acc_lo,
  input  logic              cmd_take_in,
  input  logic              cmd_load_out,
  input  logic              cmd_int_on,
  input  logic              cmd_int_off,
  input  logic              fetch_busy,
  input  logic              cycle_start,
  input  logic [ADDR_W-1:0] pc_in,
  output logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              overrun,
  output logic [DATA_W-1:0] out_data,
  output logic              out_ready,
  output logic              int_enable,
  output logic              int_pending,
  output logic              intr_busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_value
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  io_in_port #(.DATA_W(DATA_W)) u_in (
    .clk(clk), .rst_n(rst_int_n), .arrive(char_valid), .arrive_data(char_data),
    .take(cmd_take_in), .data_q(in_data), .ready_q(in_ready), .lost_q(overrun)
  );

  io_out_port #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_int_n), .load(cmd_load_out), .load_data(acc_lo),
    .done(print_done), .data_q(out_data), .ready_q(out_ready)
  );

  io_intr_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .ion(cmd_int_on), .iof(cmd_int_off),
    .flag_any(in_ready | out_ready), .fetch_busy(fetch_busy),
    .cycle_start(cycle_start), .pc_in(pc_in), .ien_q(int_enable),
    .pend_q(int_pending), .busy(intr_busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pc_load(pc_load),
    .pc_value(pc_value)
  );
endmodule

// File: rtl/io_intr_unit_checker.sv
module io_intr_unit_checker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_ok_n,
  input logic              char_valid,
  input logic              cmd_load_out,
  input logic              cmd_int_off,
  input logic              fetch_busy,
  input logic              cycle_start,
  input logic [DATA_W-1:0] in_data,
  input logic              in_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_ready,
  input logic              int_enable,
  input logic              int_pending,
  input logic              intr_busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              pc_load
);
  assert_hold_in_R3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (char_valid && in_ready) |=> $stable(in_data));

  assert_ignore_load_R6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (cmd_load_out && !out_ready) |=> $stable(out_data));

  assert_off_wins_R7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    cmd_int_off |=> !int_enable);

  assert_no_set_in_fetch_R8: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (fetch_busy && !int_pending && !intr_busy) |=> !int_pending);

  assert_save_addr_R9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    mem_we |-> (mem_addr == '0 && pc_load && intr_busy));

  assert_entry_clears_R9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    mem_we |-> ##2 (!int_enable && !int_pending && !intr_busy));

  assert_quiet_boundary_R10: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (cycle_start && !int_pending && !intr_busy) |=> !mem_we);
endmodule

bind io_intr_unit io_intr_unit_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_ok_n(rst_int_n), .char_valid(char_valid),
  .cmd_load_out(cmd_load_out), .cmd_int_off(cmd_int_off),
  .fetch_busy(fetch_busy), .cycle_start(cycle_start), .in_data(in_data),
  .in_ready(in_ready), .out_data(out_data), .out_ready(out_ready),
  .int_enable(int_enable), .int_pending(int_pending), .intr_busy(intr_busy),
  .mem_we(mem_we), .mem_addr(mem_addr), .pc_load(pc_load)
);

// File: tb/io_intr_unit_bench.sv
module io_intr_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        char_valid, print_done, cmd_take_in, cmd_load_out;
  logic        cmd_int_on, cmd_int_off, fetch_busy, cycle_start;
  logic [7:0]  char_data, acc_lo;
  logic [11:0] pc_in;
  logic [7:0]  in_data, out_data;
  logic        in_ready, overrun, out_ready, int_enable, int_pending;
  logic        intr_busy, mem_we, pc_load;
  logic [11:0] mem_addr, pc_value;
  logic [15:0] mem_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  io_intr_unit u_io_intr_unit (
    .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
    .print_done(print_done), .acc_lo(acc_lo), .cmd_take_in(cmd_take_in),
    .cmd_load_out(cmd_load_out), .cmd_int_on(cmd_int_on),
    .cmd_int_off(cmd_int_off), .fetch_busy(fetch_busy),
    .cycle_start(cycle_start), .pc_in(pc_in), .in_data(in_data),
    .in_ready(in_ready), .overrun(overrun), .out_data(out_data),
    .out_ready(out_ready), .int_enable(int_enable), .int_pending(int_pending),
    .intr_busy(intr_busy), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .pc_load(pc_load), .pc_value(pc_value)
  );

  typedef struct {
    string       req;
    int          sel;
    logic [15:0] exp;
  } exp_item_t;

  exp_item_t sb_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic logic [15:0] observe(int sel);
    case (sel)
      0:  return {8'h0, in_data};
      1:  return {15'h0, in_ready};
      2:  return {8'h0, out_data};
      3:  return {15'h0, out_ready};
      4:  return {15'h0, overrun};
      5:  return {15'h0, int_enable};
      6:  return {15'h0, int_pending};
      7:  return {15'h0, mem_we};
      8:  return {4'h0, mem_addr};
      9:  return mem_wdata;
      10: return {15'h0, pc_load};
      11: return {4'h0, pc_value};
      default: return {15'h0, intr_busy};
    endcase
  endfunction

  // monitor: pops expected items mid-cycle and compares
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_item_t it;
      logic [15:0] act;
      it = sb_q.pop_front();
      act = observe(it.sel);
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic expect_val(string req, int sel, logic [15:0] exp);
    exp_item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    char_valid = 0; print_done = 0; cmd_take_in = 0; cmd_load_out = 0;
    cmd_int_on = 0; cmd_int_off = 0; cycle_start = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: all requirements actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    char_data = 8'h00; acc_lo = 8'h00; pc_in = 12'h000; fetch_busy = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    expect_val("R1", 1, 16'd0);  expect_val("R1", 3, 16'd1);
    expect_val("R1", 4, 16'd0);  expect_val("R1", 5, 16'd0);
    expect_val("R1", 6, 16'd0);  expect_val("R1", 12, 16'd0);
    tick();

    // R2 character capture
    char_valid = 1; char_data = 8'hA5; tick(); idle_inputs();
    expect_val("R2", 0, 16'h00A5); expect_val("R2", 1, 16'd1);
    tick();

    // R3 drop while full
    char_valid = 1; char_data = 8'h3C; tick(); idle_inputs();
    expect_val("R3", 0, 16'h00A5); expect_val("R3", 4, 16'd1);
    tick();

    // R4 take clears flag and overrun
    cmd_take_in = 1; tick(); idle_inputs();
    expect_val("R4", 1, 16'd0); expect_val("R4", 4, 16'd0);
    tick();
    // R2 after take, next character accepted
    char_valid = 1; char_data = 8'h3C; tick(); idle_inputs();
    expect_val("R2", 0, 16'h003C);
    cmd_take_in = 1; tick(); idle_inputs();
    tick();

    // R5 output load
    acc_lo = 8'h5A; cmd_load_out = 1; tick(); idle_inputs();
    expect_val("R5", 2, 16'h005A); expect_val("R5", 3, 16'd0);
    tick();

    // R6 load while busy ignored
    acc_lo = 8'hFF; cmd_load_out = 1; tick(); idle_inputs();
    expect_val("R6", 2, 16'h005A); expect_val("R6", 3, 16'd0);
    tick();

    // R5 print done
    print_done = 1; tick(); idle_inputs();
    expect_val("R5", 3, 16'd1);
    tick();

    // R8 enable off: no pending even outside fetch
    fetch_busy = 0; tick(); tick();
    expect_val("R8", 6, 16'd0);
    fetch_busy = 1; tick();

    // R7 enable on inside fetch window; R8 pending stays clear
    cmd_int_on = 1; tick(); idle_inputs();
    expect_val("R7", 5, 16'd1); expect_val("R8", 6, 16'd0);
    tick();
    // R7 both: off wins
    cmd_int_on = 1; cmd_int_off = 1; tick(); idle_inputs();
    expect_val("R7", 5, 16'd0);
    cmd_int_on = 1; tick(); idle_inputs();
    expect_val("R7", 5, 16'd1);
    tick();

    // R10 boundary with nothing pending
    cycle_start = 1;
    expect_val("R10", 12, 16'd0); expect_val("R10", 7, 16'd0);
    expect_val("R10", 10, 16'd0);
    tick(); idle_inputs();
    expect_val("R10", 7, 16'd0); expect_val("R10", 10, 16'd0);
    tick();

    // R8 leave fetch window: pending set
    fetch_busy = 0; tick(); fetch_busy = 1;
    expect_val("R8", 6, 16'd1);
    tick();

    // R9 interrupt entry
    pc_in = 12'h123; cycle_start = 1;
    expect_val("R9", 12, 16'd1); expect_val("R9", 7, 16'd0);
    tick(); idle_inputs(); pc_in = 12'h456;
    expect_val("R9", 7, 16'd1);  expect_val("R9", 8, 16'h0000);
    expect_val("R9", 9, 16'h0123); expect_val("R9", 10, 16'd1);
    expect_val("R9", 11, 16'h0000);
    tick();
    expect_val("R9", 7, 16'd0);  expect_val("R9", 10, 16'd1);
    expect_val("R9", 11, 16'h0001); expect_val("R9", 5, 16'd1);
    tick();
    expect_val("R9", 5, 16'd0);  expect_val("R9", 6, 16'd0);
    expect_val("R9", 12, 16'd0); expect_val("R9", 10, 16'd0);
    tick();
    tick();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule